// File: doc/BRIEF.md
# Interlocked Memory Queue Engine

This block lets a network port trade work with software through doubly linked lists that live in shared, word-addressed memory. After a start strobe it fetches three words over a simple channel: the base address of its control area, the interrupt level, and a spare word that it throws away. Once running, each service pass first hands the entry it is holding back to software by linking it onto the tail of the response list. It then takes the next entry off the head of the command list and holds it.

Every list header is three words: an interlock word, a forward link and a back link. A list node keeps its forward link at its own address and its back link at the next word. A header may be touched only while the top bit of its interlock word is 1. When the interlock is held elsewhere, the pass gives up and a retry timer starts the next pass later. A pass starts on a command-available pulse or when the retry timer expires. Linking an entry onto an empty response list raises the response-available flag and pulses the interrupt.

Top module: `memq_engine`

## Requirements
- R1: After a `start_i` pulse while stopped, the block reads three channel words. The low AW bits of the first word become the control area base. The low 3 bits of the second word appear on `irq_level_o`. The third word is discarded. `run_o` rises after the third word is accepted, and `start_i` has no effect while `run_o` is 1.
- R2: A channel error on any of the three reads sets `err_o`, drives `err_code_o` to octal 7762, pulses `irq_o` for one cycle and leaves `run_o` at 0. A later `start_i` clears `err_o` and tries again.
- R3: A `cmd_avail_i` pulse sets `cmd_avail_o` and starts a service pass. While `run_o` is 0, no memory access is made.
- R4: A header is used only if bit DW-1 of its interlock word is 1. If that bit is 0, the pass ends with no write. Exactly RETRY_CYC cycles with no memory request follow, and then the pass starts again.
- R5: The command list header is at base+0, with its forward link at +1 and its back link at +2. If the forward link equals base+1, the list is empty: nothing is written and `cmd_avail_o` is cleared. Otherwise the first node F is held, the header forward link is set to F's forward link N, and word N+1 is set to base+1.
- R6: To insert held node E on the response list (header at base+4), the block writes base+5 into word E and the old header back link T into word E+1. It then writes E into word T and into the header back link at base+6.
- R7: If T equals base+5 before an insertion, `rsp_avail_o` is set and `irq_o` pulses for one cycle. Otherwise neither happens. `rsp_ack_i` clears `rsp_avail_o`.
- R8: A pass inserts the held node before it removes the next one, so nodes reach the response list in the order they left the command list.
- R9: The memory request holds its address, direction and write data until `mem_ack_i` is seen, and each accepted access moves the engine on by one step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start strobe |
| ch_req_o | output | 1 | Channel read request |
| ch_ack_i | input | 1 | Channel word accepted |
| ch_err_i | input | 1 | Channel read failed |
| ch_data_i | input | DW | Channel read data |
| cmd_avail_i | input | 1 | Command-available pulse from software |
| rsp_ack_i | input | 1 | Clears the response-available flag |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | AW | Word address |
| mem_wdata_o | output | DW | Write data |
| mem_ack_i | input | 1 | Access completes this cycle |
| mem_rdata_i | input | DW | Read data, valid with acknowledge |
| run_o | output | 1 | Port running |
| irq_o | output | 1 | One-cycle interrupt pulse |
| irq_level_o | output | LVL_W | Interrupt level from start |
| cmd_avail_o | output | 1 | Command-available flag |
| rsp_avail_o | output | 1 | Response-available flag |
| err_o | output | 1 | Start failed |
| err_code_o | output | ERR_W | Error code, octal 7762 while err_o is 1 |

## Verification
The hardest case to reach is a pass that finds a header locked and then has to resume on the retry timer alone. To get there, the stimulus clears the interlock word behind the engine's back and waits for the failing read of that word. It then counts the quiet cycles on the memory request and releases the lock halfway through the wait, so the retry proceeds without any further command pulse. The same is done on the response header while a node is held. Passes run with and without memory wait states. Every write is checked in order against a list model held in the bench.

// File: rtl/memq_pkg.sv
// Shared constants and state types for the memory queue engine.
// Assumes word addressing; node links are whole word addresses.
package memq_pkg;

    localparam int unsigned FWD_OFS     = 1;   // header forward link offset
    localparam int unsigned BACK_OFS    = 2;   // header back link offset
    localparam int unsigned RSP_HDR_OFS = 4;   // response header offset from base
    localparam logic [11:0] CHAN_ERR_CODE = 12'o7762;

    typedef enum logic [1:0] {
        L_IDLE,
        L_BASE,
        L_LEVEL,
        L_SPARE
    } load_state_t;

    typedef enum logic [3:0] {
        Q_IDLE,
        Q_PUT_LOCK,
        Q_PUT_EFL,
        Q_PUT_BLK,
        Q_PUT_EBL,
        Q_PUT_TAIL,
        Q_PUT_HBL,
        Q_GET_LOCK,
        Q_GET_FL,
        Q_GET_NXT,
        Q_GET_HFL,
        Q_GET_NBL
    } q_state_t;

endpackage

// File: rtl/memq_chan_loader.sv
// Start sequence: fetches base address, interrupt level and a spare word
// over the channel. Assumes ch_ack_i/ch_err_i answer only a raised request.
module memq_chan_loader
    import memq_pkg::*;
#(
    parameter int DW    = 36,
    parameter int AW    = 23,
    parameter int LVL_W = 3,
    parameter int ERR_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             ch_req_o,
    input  logic             ch_ack_i,
    input  logic             ch_err_i,
    input  logic [DW-1:0]    ch_data_i,
    output logic             run_o,
    output logic [AW-1:0]    base_o,
    output logic [LVL_W-1:0] level_o,
    output logic             err_o,
    output logic [ERR_W-1:0] err_code_o,
    output logic             fail_o
);

    load_state_t      state_q;
    logic             run_q;
    logic             err_q;
    logic [AW-1:0]    base_q;
    logic [LVL_W-1:0] level_q;
    logic             unused_hi;

    assign unused_hi  = ^ch_data_i[DW-1:AW];
    assign ch_req_o   = (state_q != L_IDLE);
    assign fail_o     = ch_req_o && ch_err_i;
    assign run_o      = run_q;
    assign err_o      = err_q;
    assign base_o     = base_q;
    assign level_o    = level_q;
    assign err_code_o = err_q ? ERR_W'(CHAN_ERR_CODE) : '0;

    // Step through the three channel reads and record their results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= L_IDLE;
            run_q   <= 1'b0;
            err_q   <= 1'b0;
            base_q  <= '0;
            level_q <= '0;
        end else if (state_q == L_IDLE) begin
            if (start_i && !run_q) begin
                state_q <= L_BASE;
                err_q   <= 1'b0;
            end
        end else if (ch_err_i) begin
            err_q   <= 1'b1;
            state_q <= L_IDLE;
        end else if (ch_ack_i) begin
            unique case (state_q)
                L_BASE: begin
                    base_q  <= ch_data_i[AW-1:0];
                    state_q <= L_LEVEL;
                end
                L_LEVEL: begin
                    level_q <= ch_data_i[LVL_W-1:0];
                    state_q <= L_SPARE;
                end
                default: begin
                    run_q   <= 1'b1;
                    state_q <= L_IDLE;
                end
            endcase
        end
    end

    // R2: a failed start never leaves the port running.
    a_r2_err_excludes_run: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_q && run_q));
    // R1: the channel is quiet once the port runs.
    a_r1_chan_quiet_running: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> !ch_req_o);

endmodule

// File: rtl/memq_retry_timer.sv
// Retry delay: after a load, fires a one-cycle pulse RETRY_CYC cycles later.
// Assumes RETRY_CYC >= 1; a new load restarts the count.
module memq_retry_timer #(
    parameter int RETRY_CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic fire_o
);

    localparam int CW = $clog2(RETRY_CYC + 1);

    logic [CW-1:0] cnt_q;

    assign fire_o = (cnt_q == CW'(1));

    // Count down from the retry window after each locked header.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= CW'(RETRY_CYC);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - CW'(1);
    end

endmodule

// File: rtl/memq_queue_fsm.sv
// Service pass sequencer: inserts the held node on the response list, then
// removes the next command node. One memory access per state.
// Assumes DW > AW + 1 and links carried in the low AW bits of a word.
module memq_queue_fsm
    import memq_pkg::*;
#(
    parameter int DW = 36,
    parameter int AW = 23
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic [AW-1:0] base_i,
    input  logic          trig_i,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o,
    input  logic          mem_ack_i,
    input  logic [DW-1:0] mem_rdata_i,
    output logic          lock_fail_o,
    output logic          q_empty_o,
    output logic          rsp_new_o
);

    q_state_t      state_q;
    logic          pend_q;
    logic          held_v_q;
    logic [AW-1:0] held_q;
    logic [AW-1:0] blink_q;
    logic [AW-1:0] flink_q;
    logic [AW-1:0] next_q;
    logic [AW-1:0] cmd_base;
    logic [AW-1:0] rsp_base;
    logic [AW-1:0] rd_link;
    logic          xfer;
    logic          pass_go;
    logic          locked;
    logic          unused_mid;

    assign cmd_base    = base_i;
    assign rsp_base    = base_i + AW'(RSP_HDR_OFS);
    assign rd_link     = mem_rdata_i[AW-1:0];
    assign unused_mid  = ^mem_rdata_i[DW-2:AW];
    assign xfer        = mem_req_o && mem_ack_i;
    assign pass_go     = (state_q == Q_IDLE) && run_i && (trig_i || pend_q);
    assign locked      = !mem_rdata_i[DW-1];
    assign lock_fail_o = xfer && locked &&
                         ((state_q == Q_PUT_LOCK) || (state_q == Q_GET_LOCK));
    assign q_empty_o   = xfer && (state_q == Q_GET_FL) &&
                         (rd_link == cmd_base + AW'(FWD_OFS));
    assign rsp_new_o   = xfer && (state_q == Q_PUT_HBL) &&
                         (blink_q == rsp_base + AW'(FWD_OFS));

    // Address, direction and data of the access each state performs.
    always_comb begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        unique case (state_q)
            Q_PUT_LOCK: mem_addr_o = rsp_base;
            Q_PUT_EFL: begin
                mem_we_o    = 1'b1;
                mem_addr_o  = held_q;
                mem_wdata_o = DW'(rsp_base + AW'(FWD_OFS));
            end
            Q_PUT_BLK:  mem_addr_o = rsp_base + AW'(BACK_OFS);
            Q_PUT_EBL: begin
                mem_we_o    = 1'b1;
                mem_addr_o  = held_q + AW'(1);
                mem_wdata_o = DW'(blink_q);
            end
            Q_PUT_TAIL: begin
                mem_we_o    = 1'b1;
                mem_addr_o  = blink_q;
                mem_wdata_o = DW'(held_q);
            end
            Q_PUT_HBL: begin
                mem_we_o    = 1'b1;
                mem_addr_o  = rsp_base + AW'(BACK_OFS);
                mem_wdata_o = DW'(held_q);
            end
            Q_GET_LOCK: mem_addr_o = cmd_base;
            Q_GET_FL:   mem_addr_o = cmd_base + AW'(FWD_OFS);
            Q_GET_NXT:  mem_addr_o = flink_q;
            Q_GET_HFL: begin
                mem_we_o    = 1'b1;
                mem_addr_o  = cmd_base + AW'(FWD_OFS);
                mem_wdata_o = DW'(next_q);
            end
            Q_GET_NBL: begin
                mem_we_o    = 1'b1;
                mem_addr_o  = next_q + AW'(1);
                mem_wdata_o = DW'(cmd_base + AW'(FWD_OFS));
            end
            default:    mem_req_o = 1'b0;
        endcase
    end

    // Remember a trigger that arrives while a pass is busy.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (pass_go)
            pend_q <= 1'b0;
        else if (trig_i && run_i)
            pend_q <= 1'b1;
    end

    // Advance the pass one accepted access at a time and capture links.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= Q_IDLE;
            held_v_q <= 1'b0;
            held_q   <= '0;
            blink_q  <= '0;
            flink_q  <= '0;
            next_q   <= '0;
        end else if (state_q == Q_IDLE) begin
            if (pass_go)
                state_q <= held_v_q ? Q_PUT_LOCK : Q_GET_LOCK;
        end else if (xfer) begin
            unique case (state_q)
                Q_PUT_LOCK: state_q <= locked ? Q_IDLE : Q_PUT_EFL;
                Q_PUT_EFL:  state_q <= Q_PUT_BLK;
                Q_PUT_BLK: begin
                    blink_q <= rd_link;
                    state_q <= Q_PUT_EBL;
                end
                Q_PUT_EBL:  state_q <= Q_PUT_TAIL;
                Q_PUT_TAIL: state_q <= Q_PUT_HBL;
                Q_PUT_HBL: begin
                    held_v_q <= 1'b0;
                    state_q  <= Q_GET_LOCK;
                end
                Q_GET_LOCK: state_q <= locked ? Q_IDLE : Q_GET_FL;
                Q_GET_FL: begin
                    flink_q <= rd_link;
                    state_q <= q_empty_o ? Q_IDLE : Q_GET_NXT;
                end
                Q_GET_NXT: begin
                    next_q  <= rd_link;
                    state_q <= Q_GET_HFL;
                end
                Q_GET_HFL:  state_q <= Q_GET_NBL;
                default: begin
                    held_q   <= flink_q;
                    held_v_q <= 1'b1;
                    state_q  <= Q_IDLE;
                end
            endcase
        end
    end

    // R9: an unanswered request stays put.
    a_r9_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) &&
                                       $stable(mem_we_o) && $stable(mem_wdata_o)));
    // R3: a stopped port never touches memory.
    a_r3_quiet_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |-> !mem_req_o);
    // R4: a locked header ends the pass with the bus idle.
    a_r4_idle_after_lock: assert property (@(posedge clk) disable iff (!rst_n)
        lock_fail_o |=> !mem_req_o);

endmodule

// File: rtl/memq_engine.sv
// Top of the memory queue engine: start loader, retry timer, pass sequencer
// and the software-visible flags. Assumes a single memory master.
module memq_engine
    import memq_pkg::*;
#(
    parameter int DW        = 36,
    parameter int AW        = 23,
    parameter int LVL_W     = 3,
    parameter int ERR_W     = 12,
    parameter int RETRY_CYC = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             ch_req_o,
    input  logic             ch_ack_i,
    input  logic             ch_err_i,
    input  logic [DW-1:0]    ch_data_i,
    input  logic             cmd_avail_i,
    input  logic             rsp_ack_i,
    output logic             mem_req_o,
    output logic             mem_we_o,
    output logic [AW-1:0]    mem_addr_o,
    output logic [DW-1:0]    mem_wdata_o,
    input  logic             mem_ack_i,
    input  logic [DW-1:0]    mem_rdata_i,
    output logic             run_o,
    output logic             irq_o,
    output logic [LVL_W-1:0] irq_level_o,
    output logic             cmd_avail_o,
    output logic             rsp_avail_o,
    output logic             err_o,
    output logic [ERR_W-1:0] err_code_o
);

    logic          run;
    logic [AW-1:0] base;
    logic          load_fail;
    logic          lock_fail;
    logic          q_empty;
    logic          rsp_new;
    logic          retry_fire;
    logic          irq_q;
    logic          cqa_q;
    logic          rqa_q;

    assign run_o       = run;
    assign irq_o       = irq_q;
    assign cmd_avail_o = cqa_q;
    assign rsp_avail_o = rqa_q;

    memq_chan_loader #(.DW(DW), .AW(AW), .LVL_W(LVL_W), .ERR_W(ERR_W)) loader_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .ch_req_o   (ch_req_o),
        .ch_ack_i   (ch_ack_i),
        .ch_err_i   (ch_err_i),
        .ch_data_i  (ch_data_i),
        .run_o      (run),
        .base_o     (base),
        .level_o    (irq_level_o),
        .err_o      (err_o),
        .err_code_o (err_code_o),
        .fail_o     (load_fail)
    );

    memq_retry_timer #(.RETRY_CYC(RETRY_CYC)) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (lock_fail),
        .fire_o (retry_fire)
    );

    memq_queue_fsm #(.DW(DW), .AW(AW)) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (run),
        .base_i      (base),
        .trig_i      (cmd_avail_i || retry_fire),
        .mem_req_o   (mem_req_o),
        .mem_we_o    (mem_we_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o),
        .mem_ack_i   (mem_ack_i),
        .mem_rdata_i (mem_rdata_i),
        .lock_fail_o (lock_fail),
        .q_empty_o   (q_empty),
        .rsp_new_o   (rsp_new)
    );

    // Interrupt pulse and the two availability flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            cqa_q <= 1'b0;
            rqa_q <= 1'b0;
        end else begin
            irq_q <= rsp_new || load_fail;
            if (cmd_avail_i)
                cqa_q <= 1'b1;
            else if (q_empty)
                cqa_q <= 1'b0;
            if (rsp_new)
                rqa_q <= 1'b1;
            else if (rsp_ack_i)
                rqa_q <= 1'b0;
        end
    end

    // R7: a node linked onto an empty response list raises flag and interrupt.
    a_r7_irq_on_first_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_new |=> (irq_q && rqa_q));
    // R5: an empty command list clears the flag unless a new pulse arrives.
    a_r5_empty_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (q_empty && !cmd_avail_i) |=> !cqa_q);

endmodule

// File: tb/memq_engine_tb_top.sv
`timescale 1ns/1ps
module memq_engine_tb_top;

    localparam int DW = 36;
    localparam int AW = 23;
    localparam int RETRY = 100;
    localparam logic [DW-1:0] SIGN = 36'h800000000;
    localparam logic [AW-1:0] CB = 23'd64;
    localparam logic [AW-1:0] RB = 23'd68;
    localparam logic [AW-1:0] NA = 23'd16;
    localparam logic [AW-1:0] NB = 23'd20;
    localparam logic [AW-1:0] NC = 23'd24;
    localparam logic [AW-1:0] ND = 23'd28;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic cmd_avail_i = 1'b0;
    logic rsp_ack_i = 1'b0;
    logic ch_req_o, ch_ack_i, ch_err_i;
    logic [DW-1:0] ch_data_i;
    logic mem_req_o, mem_we_o, mem_ack_i;
    logic [AW-1:0] mem_addr_o;
    logic [DW-1:0] mem_wdata_o, mem_rdata_i;
    logic run_o, irq_o, cmd_avail_o, rsp_avail_o, err_o;
    logic [2:0] irq_level_o;
    logic [11:0] err_code_o;

    logic [DW-1:0] mem [0:255];
    logic [DW-1:0] chw [0:2];
    int unsigned   ch_idx;
    int unsigned   err_at = 3;
    logic          ws_en = 1'b0;
    logic          tick;
    logic          bd_we = 1'b0;
    logic [7:0]    bd_addr = '0;
    logic [DW-1:0] bd_data = '0;

    logic [AW+DW-1:0] exp_q [$];
    int n_chk = 0, n_err = 0, mon_chk = 0, mon_err = 0;
    int irq_cnt = 0, req_cnt = 0, ch_cnt = 0;

    always #2.5 clk = ~clk;

    memq_engine dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .ch_req_o(ch_req_o), .ch_ack_i(ch_ack_i), .ch_err_i(ch_err_i), .ch_data_i(ch_data_i),
        .cmd_avail_i(cmd_avail_i), .rsp_ack_i(rsp_ack_i),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
        .run_o(run_o), .irq_o(irq_o), .irq_level_o(irq_level_o),
        .cmd_avail_o(cmd_avail_o), .rsp_avail_o(rsp_avail_o),
        .err_o(err_o), .err_code_o(err_code_o)
    );

    // Memory and channel models.
    assign mem_ack_i   = mem_req_o && (!ws_en || tick);
    assign mem_rdata_i = mem[mem_addr_o[7:0]];
    assign ch_err_i    = ch_req_o && (ch_idx == err_at);
    assign ch_ack_i    = ch_req_o && (ch_idx != err_at);
    assign ch_data_i   = chw[ch_idx > 2 ? 2 : ch_idx];

    always @(posedge clk) begin
        tick <= !rst_n ? 1'b0 : !tick;
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= '0;
        end else if (mem_req_o && mem_we_o && mem_ack_i)
            mem[mem_addr_o[7:0]] <= mem_wdata_o;
        else if (bd_we)
            mem[bd_addr] <= bd_data;
        if (start_i) ch_idx <= 0;
        else if (ch_req_o) ch_idx <= ch_idx + 1;
    end

    // Monitor: pops expected writes and counts events.
    always @(negedge clk) begin
        logic [AW+DW-1:0] item;
        if (rst_n) begin
            if (irq_o) irq_cnt++;
            if (mem_req_o) req_cnt++;
            if (ch_req_o) ch_cnt++;
            if (mem_req_o && mem_we_o && mem_ack_i) begin
                mon_chk++;
                if (exp_q.size() == 0) begin
                    mon_err++;
                    $display("FAIL R5/R6 write: actual %0d<=%0h expected none", mem_addr_o, mem_wdata_o);
                end else begin
                    item = exp_q.pop_front();
                    if (item !== {mem_addr_o, mem_wdata_o}) begin
                        mon_err++;
                        $display("FAIL R5/R6 write: actual %0d<=%0h expected %0d<=%0h",
                                 mem_addr_o, mem_wdata_o, item[AW+DW-1:DW], item[DW-1:0]);
                    end
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", n_chk + mon_chk + 1, n_err + mon_err + 1);
        $finish;
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bd(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bd_addr = a[7:0]; bd_data = d; bd_we = 1'b1;
        @(negedge clk);
        bd_we = 1'b0;
    endtask

    task automatic ew(input logic [AW-1:0] a, input logic [AW-1:0] d);
        exp_q.push_back({a, DW'(d)});
    endtask

    task automatic pulse_cmd();
        @(negedge clk); cmd_avail_i = 1'b1;
        @(negedge clk); cmd_avail_i = 1'b0;
    endtask

    task automatic do_start(input logic [DW-1:0] w0, input logic [DW-1:0] w1, input int unsigned e);
        chw[0] = w0; chw[1] = w1; chw[2] = 36'o777777777777; err_at = e;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    initial begin
        int c0, gap;
        chw[0] = '0; chw[1] = '0; chw[2] = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset run_o", run_o, 0);
        chk("R2 reset err_o", err_o, 0);
        chk("R7 reset irq/rsp_avail", {irq_o, rsp_avail_o}, 0);
        chk("R9 reset mem_req_o", mem_req_o, 0);

        // R3: no memory traffic before start
        pulse_cmd();
        repeat (20) @(negedge clk);
        chk("R3 no access while stopped", req_cnt, 0);
        chk("R3 cmd_avail_o set", cmd_avail_o, 1);

        // R2: channel error on second word
        c0 = irq_cnt;
        do_start(36'd64, 36'd5, 1);
        chk("R2 err_o", err_o, 1);
        chk("R2 err_code_o", err_code_o, 12'o7762);
        chk("R2 run_o stays 0", run_o, 0);
        chk("R2 irq pulse", irq_cnt - c0, 1);

        // R1: good start, upper bits of words ignored
        do_start(36'h100000040, 36'o770000000015, 3);
        chk("R1 run_o", run_o, 1);
        chk("R1 irq_level_o", irq_level_o, 5);
        chk("R2 err cleared by start", err_o, 0);
        c0 = ch_cnt;
        do_start(36'd0, 36'd0, 3);
        chk("R1 start ignored while running", ch_cnt - c0, 0);
        chk("R1 level kept", irq_level_o, 5);

        // headers: unlocked, both lists empty
        bd(CB, SIGN); bd(CB + 1, 36'(CB + 1)); bd(CB + 2, 36'(CB + 1));
        bd(RB, SIGN); bd(RB + 1, 36'(RB + 1)); bd(RB + 2, 36'(RB + 1));

        // R5: empty command list
        pulse_cmd();
        repeat (40) @(negedge clk);
        chk("R5 empty list clears cmd_avail_o", cmd_avail_o, 0);

        // command list A -> B -> C
        bd(CB + 1, 36'(NA)); bd(CB + 2, 36'(NC));
        bd(NA, 36'(NB)); bd(NA + 1, 36'(CB + 1));
        bd(NB, 36'(NC)); bd(NB + 1, 36'(NA));
        bd(NC, 36'(CB + 1)); bd(NC + 1, 36'(NB));

        // R5: remove A
        ew(CB + 1, NB); ew(NB + 1, CB + 1);
        pulse_cmd();
        repeat (40) @(negedge clk);
        chk("R5 writes done", exp_q.size(), 0);
        chk("R5 cmd_avail_o stays", cmd_avail_o, 1);
        chk("R7 no rsp yet", rsp_avail_o, 0);

        // R6/R7/R8: insert A onto empty response list, then remove B
        c0 = irq_cnt;
        ew(NA, RB + 1); ew(NA + 1, RB + 1); ew(RB + 1, NA); ew(RB + 2, NA);
        ew(CB + 1, NC); ew(NC + 1, CB + 1);
        pulse_cmd();
        repeat (40) @(negedge clk);
        chk("R6 writes done", exp_q.size(), 0);
        chk("R7 rsp_avail_o set", rsp_avail_o, 1);
        chk("R7 one irq pulse", irq_cnt - c0, 1);
        @(negedge clk); rsp_ack_i = 1'b1;
        @(negedge clk); rsp_ack_i = 1'b0;
        chk("R7 rsp_ack_i clears", rsp_avail_o, 0);

        // R9 with wait states; insert B (non-empty list), remove C
        ws_en = 1'b1;
        c0 = irq_cnt;
        ew(NB, RB + 1); ew(NB + 1, NA); ew(NA, NB); ew(RB + 2, NB);
        ew(CB + 1, CB + 1); ew(CB + 2, CB + 1);
        pulse_cmd();
        repeat (60) @(negedge clk);
        chk("R9 writes done under wait states", exp_q.size(), 0);
        chk("R7 no irq on non-empty list", irq_cnt - c0, 0);
        chk("R7 rsp_avail_o stays 0", rsp_avail_o, 0);
        chk("R8 rsp head is A", mem[RB + 1], NA);
        chk("R8 A then B", mem[NA], NB);
        chk("R8 B back link", mem[NB + 1], NA);

        // insert C, command list now empty
        ew(NC, RB + 1); ew(NC + 1, NB); ew(NB, NC); ew(RB + 2, NC);
        pulse_cmd();
        repeat (60) @(negedge clk);
        ws_en = 1'b0;
        chk("R8 writes done", exp_q.size(), 0);
        chk("R8 tail is C", mem[RB + 2], NC);
        chk("R5 cmd_avail_o cleared", cmd_avail_o, 0);

        // R4: locked command header, release mid-wait
        bd(CB, '0);
        bd(CB + 1, 36'(ND)); bd(CB + 2, 36'(ND));
        bd(ND, 36'(CB + 1)); bd(ND + 1, 36'(CB + 1));
        ew(CB + 1, CB + 1); ew(CB + 2, CB + 1);
        pulse_cmd();
        c0 = 0;
        while (!(mem_req_o && mem_ack_i && !mem_we_o && mem_addr_o == CB) && c0 < 100) begin
            @(negedge clk); c0++;
        end
        chk("R4 lock read seen", mem_addr_o, CB);
        gap = 0;
        bd_addr = CB[7:0]; bd_data = SIGN;
        for (int k = 0; k < 1000; k++) begin
            @(negedge clk);
            bd_we = (gap == 50);
            if (mem_req_o) break;
            gap++;
        end
        bd_we = 1'b0;
        chk("R4 retry gap", gap, RETRY);
        repeat (30) @(negedge clk);
        chk("R4 retry completes", exp_q.size(), 0);
        chk("R4 cmd_avail_o kept", cmd_avail_o, 1);

        // R4: locked response header while D is held
        bd(RB, '0);
        c0 = irq_cnt;
        ew(ND, RB + 1); ew(ND + 1, NC); ew(NC, ND); ew(RB + 2, ND);
        pulse_cmd();
        repeat (30) @(negedge clk);
        chk("R4 no write while locked", exp_q.size(), 4);
        bd(RB, SIGN);
        repeat (150) @(negedge clk);
        chk("R4 response retry completes", exp_q.size(), 0);
        chk("R5 empty after retry", cmd_avail_o, 0);
        chk("R7 no irq on non-empty list", irq_cnt - c0, 0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk + mon_chk, n_err + mon_err);
        $finish;
    end

endmodule